// File: doc/BRIEF.md
# Backplane Window Access Sequencer

This block sits on the host side of an SDIO link to a peripheral whose internal 32-bit backplane is reached through a 64 KiB sliding window. A client asks for a single 16-bit access, a single 32-bit access or a FIFO block transfer at a full 32-bit backplane address. The block converts each request into an ordered series of SDIO command descriptors. Each descriptor is either a byte-wide direct command (CMD52) or an extended command (CMD53) with its argument fields. The descriptors go out on a valid/ready command port. Every descriptor is answered by one response on a return port that carries an error flag and read data.

The block holds a shadow copy of the window base that the card is currently using. Only when a request falls outside that base does it first emit the three byte writes that move the window. It computes the in-window offset and marks 32-bit accesses with offset bit 15. It cuts FIFO transfers into 64-byte block-mode commands plus a byte-mode tail. After every single 32-bit write it adds a dummy 32-bit read. Bit serialisation, CRC and interrupts belong to the SD host beneath it.

Top module: `bpw_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_valid` and `done_valid` are 0, and the window shadow is invalid, so the first accepted request, and the first one after any reset, begins with window writes.
- R2: On a window miss the block emits three CMD52 writes (`cmd_ext`=0, `cmd_write`=1, `cmd_raw`=0, `cmd_func`=1, `cmd_block`=0, `cmd_incr`=0, `cmd_count`=0). They go to register addresses 0x1000A, 0x1000B and 0x1000C in that order. Their data bytes are (base[15:8] AND 0x80), base[23:16] and base[31:24], where base = address AND 0xFFFF0000.
- R3: A request whose address bits 31:16 equal the shadow base while the shadow is valid emits no window writes.
- R4: Every CMD53 carries `cmd_addr` = {0, flag, address[14:0]}. The flag is 1 for 32-bit singles and for FIFO transfers with `req_wide`=1, and 0 otherwise. Address bit 15 never reaches the offset.
- R5: A single access (`req_kind` 0 = 16-bit, 1 = 32-bit) emits one CMD53 with `cmd_block`=0, `cmd_incr`=1 and `cmd_count` 2 or 4. On a write `cmd_wdata` carries `req_wdata`. On a read `done_rdata` returns that command's response data. `cmd_byte` is 0 on every CMD53, and `cmd_wdata` is 0 on every command other than a single write.
- R6: A single 32-bit write is followed, before completion, by a CMD53 read with `cmd_block`=0, `cmd_incr`=1, count 4 and the same `cmd_addr`. Its `done_rdata` is 0.
- R7: A FIFO request (`req_kind` 2) emits CMD53 commands with `cmd_incr`=0. First come block-mode commands (`cmd_block`=1), each with a count of min(remaining 64-byte blocks, MAX_BLKS), until len/64 blocks are covered. Then, if len mod 64 is nonzero, one byte-mode command follows with that count. `done_rdata` is 0.
- R8: A FIFO length of zero, or one that is not a multiple of the width (2, or 4 when `req_wide`=1), and `req_kind` 3 are rejected. `done_valid` pulses with `done_err`=1 on the cycle after acceptance, no command is emitted and the shadow is unchanged.
- R9: A response with `rsp_err`=1 ends the request with `done_err`=1 and no further command. If the request was moving the window, the shadow stays invalid, even when the error hits the last window write, so the next request re-programs the window. An error after the window writes keeps the new base.
- R10: At most one command is outstanding: `cmd_valid` falls after a handshake and stays low until the response. A response with no command pending is ignored. `done_valid` is a one-cycle pulse, and `req_ready` is high only when no command is pending or in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_kind | input | 2 | 0 single 16-bit, 1 single 32-bit, 2 FIFO, 3 invalid |
| req_write | input | 1 | 1 write, 0 read |
| req_wide | input | 1 | FIFO element width 4 bytes (else 2) |
| req_addr | input | 32 | Backplane byte address |
| req_len | input | LEN_W | FIFO length in bytes |
| req_wdata | input | 32 | Single-write data |
| cmd_valid | output | 1 | Descriptor present |
| cmd_ready | input | 1 | Descriptor taken |
| cmd_ext | output | 1 | 1 CMD53, 0 CMD52 |
| cmd_write | output | 1 | R/W flag |
| cmd_raw | output | 1 | CMD52 read-after-write flag |
| cmd_func | output | 3 | Function number |
| cmd_block | output | 1 | CMD53 block mode |
| cmd_incr | output | 1 | CMD53 opcode (1 incrementing) |
| cmd_addr | output | 17 | Register address / offset |
| cmd_count | output | CNT_W | Byte or block count |
| cmd_byte | output | 8 | CMD52 write data |
| cmd_wdata | output | 32 | Single-write data |
| rsp_valid | input | 1 | Response present |
| rsp_err | input | 1 | Response reports an error |
| rsp_rdata | input | 32 | Read data of the response |
| done_valid | output | 1 | Request complete (pulse) |
| done_err | output | 1 | Request failed or was rejected |
| done_rdata | output | 32 | Read result of a single read |

## Verification
A failing response and the commit of the window shadow can fall in the same cycle. This happens when the error arrives on the third window write, the very response that would otherwise make the new base valid. The bench provokes it by flagging an error on that response of a miss. It judges the outcome by whether the following request to the same window starts again with three window writes, which it must. In a second overlap, a stray response arrives while the block is idle, and the bench checks that it produces neither a completion nor a command.

// File: rtl/bpw_pkg.sv
// Package: shared encodings for the backplane window sequencer.
// Assumes the window registers sit at three consecutive addresses.
package bpw_pkg;
    typedef enum logic [1:0] {
        KIND_H16  = 2'd0,
        KIND_W32  = 2'd1,
        KIND_FIFO = 2'd2,
        KIND_BAD  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CHK, ST_WIN, ST_XFER, ST_DUMMY, ST_FBLK, ST_FREM
    } st_e;

    localparam logic [16:0] WIN_REG_BASE = 17'h1000A;
    localparam logic [2:0]  FUNC_NUM     = 3'd1;
endpackage

// File: rtl/bpw_addr_map.sv
// Address mapper: window hit test, in-window offset with width flag, and
// the register address and byte of each of the three window writes.
// Assumes idx only takes the values 0..2.
module bpw_addr_map
    import bpw_pkg::*;
(
    input  logic [31:0] addr,
    input  logic        wflag,
    input  logic        win_ok,
    input  logic [15:0] win_base,
    input  logic [1:0]  idx,
    output logic        hit,
    output logic [16:0] offset,
    output logic [16:0] reg_addr,
    output logic [7:0]  reg_byte
);
    logic [31:0] base_w;

    // Window base, hit test and offset
    always_comb begin
        base_w = addr & 32'hFFFF_0000;
        hit    = win_ok && (base_w == {win_base, 16'h0000});
        offset = 17'(addr & 32'h0000_7FFF) | (wflag ? 17'h0_8000 : 17'h0_0000);
    end

    // Register address and data byte for the current window write
    always_comb begin
        reg_addr = WIN_REG_BASE + 17'(idx);
        case (idx)
            2'd0:    reg_byte = base_w[15:8] & 8'h80;
            2'd1:    reg_byte = base_w[23:16];
            default: reg_byte = base_w[31:24];
        endcase
    end
endmodule

// File: rtl/bpw_fifo_plan.sv
// FIFO planner: validates a FIFO length against its element width and
// splits it into whole blocks and a byte remainder.
// Assumes BLK_BYTES is a power of two.
module bpw_fifo_plan #(
    parameter int LEN_W     = 16,
    parameter int BLK_BYTES = 64,
    localparam int BLK_LG   = $clog2(BLK_BYTES)
) (
    input  logic [LEN_W-1:0]  len,
    input  logic              wide,
    output logic              bad,
    output logic [LEN_W-1:0]  nblk,
    output logic [BLK_LG-1:0] rem
);
    // Length check and block/remainder split
    always_comb begin
        bad  = (len == '0) || (wide ? (len[1:0] != 2'b00) : len[0]);
        nblk = len >> BLK_LG;
        rem  = len[BLK_LG-1:0];
    end
endmodule

// File: rtl/bpw_chunk.sv
// Block chunker: block count of the next block-mode command, limited to
// the largest count one command may carry.
// Assumes MAX_BLKS fits both in CNT_W and in LEN_W bits.
module bpw_chunk #(
    parameter int LEN_W    = 16,
    parameter int MAX_BLKS = 511,
    parameter int CNT_W    = 9
) (
    input  logic [LEN_W-1:0] blk_left,
    output logic [CNT_W-1:0] chunk
);
    // Minimum of remaining blocks and the per-command limit
    always_comb begin
        if (blk_left > LEN_W'(MAX_BLKS)) chunk = CNT_W'(MAX_BLKS);
        else                             chunk = CNT_W'(blk_left);
    end
endmodule

// File: rtl/bpw_seq.sv
// Backplane window access sequencer (top). Accepts one request at a time,
// checks the window shadow, emits window writes on a miss, then the data
// commands, and pulses done. One command is outstanding at any time.
// Assumes every accepted command is answered by exactly one response.
module bpw_seq
    import bpw_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int BLK_BYTES = 64,
    parameter int MAX_BLKS  = 511,
    parameter int CNT_W     = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic             req_write,
    input  logic             req_wide,
    input  logic [31:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [31:0]      req_wdata,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic             cmd_ext,
    output logic             cmd_write,
    output logic             cmd_raw,
    output logic [2:0]       cmd_func,
    output logic             cmd_block,
    output logic             cmd_incr,
    output logic [16:0]      cmd_addr,
    output logic [CNT_W-1:0] cmd_count,
    output logic [7:0]       cmd_byte,
    output logic [31:0]      cmd_wdata,
    input  logic             rsp_valid,
    input  logic             rsp_err,
    input  logic [31:0]      rsp_rdata,
    output logic             done_valid,
    output logic             done_err,
    output logic [31:0]      done_rdata
);
    localparam int BLK_LG = $clog2(BLK_BYTES);

    st_e               st;
    logic              wait_rsp;
    logic [1:0]        widx;
    kind_e             r_kind;
    logic              r_write, r_wide;
    logic [31:0]       r_addr, r_wdata;
    logic [LEN_W-1:0]  blk_left;
    logic [BLK_LG-1:0] rem_left;
    logic              win_ok;
    logic [15:0]       win_base;

    logic              plan_bad;
    logic [LEN_W-1:0]  plan_nblk;
    logic [BLK_LG-1:0] plan_rem;
    logic              win_hit, r_wflag, reject_now, active;
    logic [16:0]       acc_off, win_reg;
    logic [7:0]        win_byte;
    logic [CNT_W-1:0]  chunk;
    logic [LEN_W-1:0]  blk_next;
    st_e               first_data;

    bpw_fifo_plan #(.LEN_W(LEN_W), .BLK_BYTES(BLK_BYTES)) u_plan (
        .len(req_len), .wide(req_wide), .bad(plan_bad),
        .nblk(plan_nblk), .rem(plan_rem)
    );

    bpw_addr_map u_map (
        .addr(r_addr), .wflag(r_wflag), .win_ok(win_ok), .win_base(win_base),
        .idx(widx), .hit(win_hit), .offset(acc_off),
        .reg_addr(win_reg), .reg_byte(win_byte)
    );

    bpw_chunk #(.LEN_W(LEN_W), .MAX_BLKS(MAX_BLKS), .CNT_W(CNT_W)) u_chunk (
        .blk_left(blk_left), .chunk(chunk)
    );

    // Decode helpers: width flag, rejection, first data state, block step
    always_comb begin
        r_wflag    = (r_kind == KIND_W32) || ((r_kind == KIND_FIFO) && r_wide);
        reject_now = (kind_e'(req_kind) == KIND_BAD) ||
                     ((kind_e'(req_kind) == KIND_FIFO) && plan_bad);
        if (r_kind != KIND_FIFO)  first_data = ST_XFER;
        else if (blk_left != '0)  first_data = ST_FBLK;
        else                      first_data = ST_FREM;
        blk_next = blk_left - LEN_W'(chunk);
        active   = (st != ST_IDLE) && (st != ST_CHK);
    end

    assign req_ready = (st == ST_IDLE);
    assign cmd_valid = active && !wait_rsp;
    assign cmd_raw   = 1'b0;
    assign cmd_func  = FUNC_NUM;

    // Command descriptor fields for the current state
    always_comb begin
        cmd_ext   = 1'b0;
        cmd_write = 1'b0;
        cmd_block = 1'b0;
        cmd_incr  = 1'b0;
        cmd_addr  = acc_off;
        cmd_count = '0;
        cmd_byte  = '0;
        cmd_wdata = '0;
        case (st)
            ST_WIN: begin
                cmd_write = 1'b1;
                cmd_addr  = win_reg;
                cmd_byte  = win_byte;
            end
            ST_XFER: begin
                cmd_ext   = 1'b1;
                cmd_write = r_write;
                cmd_incr  = 1'b1;
                cmd_count = (r_kind == KIND_W32) ? CNT_W'(4) : CNT_W'(2);
                cmd_wdata = r_write ? r_wdata : 32'h0;
            end
            ST_DUMMY: begin
                cmd_ext   = 1'b1;
                cmd_incr  = 1'b1;
                cmd_count = CNT_W'(4);
            end
            ST_FBLK: begin
                cmd_ext   = 1'b1;
                cmd_write = r_write;
                cmd_block = 1'b1;
                cmd_count = chunk;
            end
            ST_FREM: begin
                cmd_ext   = 1'b1;
                cmd_write = r_write;
                cmd_count = CNT_W'(rem_left);
            end
            default: ;
        endcase
    end

    // Sequencer state, window shadow and completion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            wait_rsp   <= 1'b0;
            widx       <= 2'd0;
            r_kind     <= KIND_H16;
            r_write    <= 1'b0;
            r_wide     <= 1'b0;
            r_addr     <= '0;
            r_wdata    <= '0;
            blk_left   <= '0;
            rem_left   <= '0;
            win_ok     <= 1'b0;
            win_base   <= '0;
            done_valid <= 1'b0;
            done_err   <= 1'b0;
            done_rdata <= '0;
        end else begin
            done_valid <= 1'b0;
            case (st)
                ST_IDLE: if (req_valid) begin
                    r_kind   <= kind_e'(req_kind);
                    r_write  <= req_write;
                    r_wide   <= req_wide;
                    r_addr   <= req_addr;
                    r_wdata  <= req_wdata;
                    blk_left <= plan_nblk;
                    rem_left <= plan_rem;
                    if (reject_now) begin
                        done_valid <= 1'b1;
                        done_err   <= 1'b1;
                        done_rdata <= '0;
                    end else begin
                        st <= ST_CHK;
                    end
                end
                ST_CHK: if (win_hit) begin
                    st <= first_data;
                end else begin
                    st     <= ST_WIN;
                    widx   <= 2'd0;
                    win_ok <= 1'b0;
                end
                default: if (!wait_rsp) begin
                    if (cmd_ready) wait_rsp <= 1'b1;
                end else if (rsp_valid) begin
                    wait_rsp <= 1'b0;
                    if (rsp_err) begin
                        st         <= ST_IDLE;
                        done_valid <= 1'b1;
                        done_err   <= 1'b1;
                        done_rdata <= '0;
                    end else begin
                        case (st)
                            ST_WIN: if (widx == 2'd2) begin
                                win_ok   <= 1'b1;
                                win_base <= r_addr[31:16];
                                st       <= first_data;
                            end else begin
                                widx <= widx + 2'd1;
                            end
                            ST_XFER: if (r_write && (r_kind == KIND_W32)) begin
                                st <= ST_DUMMY;
                            end else begin
                                st         <= ST_IDLE;
                                done_valid <= 1'b1;
                                done_err   <= 1'b0;
                                done_rdata <= r_write ? 32'h0 : rsp_rdata;
                            end
                            ST_FBLK: begin
                                blk_left <= blk_next;
                                if (blk_next == '0) begin
                                    if (rem_left != '0) begin
                                        st <= ST_FREM;
                                    end else begin
                                        st         <= ST_IDLE;
                                        done_valid <= 1'b1;
                                        done_err   <= 1'b0;
                                        done_rdata <= '0;
                                    end
                                end
                            end
                            default: begin
                                st         <= ST_IDLE;
                                done_valid <= 1'b1;
                                done_err   <= 1'b0;
                                done_rdata <= '0;
                            end
                        endcase
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/bpw_seq_chk.sv
// Checker for bpw_seq: handshake discipline and descriptor field rules.
// Assumes it is bound into bpw_seq and sees its pending-response flag.
module bpw_seq_chk #(
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [1:0]       req_kind,
    input logic             cmd_valid,
    input logic             cmd_ready,
    input logic             cmd_ext,
    input logic             cmd_write,
    input logic             cmd_raw,
    input logic             cmd_block,
    input logic             cmd_incr,
    input logic [16:0]      cmd_addr,
    input logic [CNT_W-1:0] cmd_count,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             done_valid,
    input logic             done_err,
    input logic             wait_rsp
);
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_valid); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid); // R10
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) && $stable(cmd_count)); // R10
    AST_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ext |-> cmd_write && !cmd_raw && cmd_addr[16]); // R2
    AST_EXT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ext |-> !cmd_addr[16]); // R4
    AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ext && cmd_block |-> !cmd_incr && (cmd_count != '0)); // R7
    AST_SINGLE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ext && cmd_incr |-> !cmd_block &&
        ((cmd_count == CNT_W'(2)) || (cmd_count == CNT_W'(4)))); // R5
    AST_REJECT_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && (req_kind == 2'd3) |=> done_valid && done_err); // R8
    AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        wait_rsp && rsp_valid && rsp_err |=> done_valid && done_err && !cmd_valid); // R9
endmodule

bind bpw_seq bpw_seq_chk #(.CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_bpw_seq.sv
// Bench for bpw_seq: a vector table walked by one loop against a model of
// the requirements, then directed reset and idle-response tests.
module test_bpw_seq;
    localparam int LEN_W = 16;
    localparam int CNT_W = 9;
    localparam int MAXB  = 4;
    localparam int NV    = 16;
    localparam int VW    = 92;
    localparam logic [31:0] RD_BASE = 32'hA500_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
    logic [1:0] req_kind = 2'd0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic cmd_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
    logic [31:0] rsp_rdata = '0;
    logic req_ready, cmd_valid, cmd_ext, cmd_write, cmd_raw, cmd_block, cmd_incr;
    logic [2:0] cmd_func;
    logic [16:0] cmd_addr;
    logic [CNT_W-1:0] cmd_count;
    logic [7:0] cmd_byte;
    logic [31:0] cmd_wdata, done_rdata;
    logic done_valid, done_err;

    bpw_seq #(.LEN_W(LEN_W), .BLK_BYTES(64), .MAX_BLKS(MAXB), .CNT_W(CNT_W)) i_bpw_seq (
        .clk, .rst_n, .req_valid, .req_ready, .req_kind, .req_write, .req_wide,
        .req_addr, .req_len, .req_wdata, .cmd_valid, .cmd_ready, .cmd_ext,
        .cmd_write, .cmd_raw, .cmd_func, .cmd_block, .cmd_incr, .cmd_addr,
        .cmd_count, .cmd_byte, .cmd_wdata, .rsp_valid, .rsp_err, .rsp_rdata,
        .done_valid, .done_err, .done_rdata
    );

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    logic [73:0] got [0:31];
    logic [73:0] expc [0:31];
    int n_got, n_exp;
    logic exp_err, got_err;
    logic [31:0] exp_rd, got_rd;
    logic m_ok = 1'b0;
    logic [15:0] m_base = '0;

    // {kind, write, wide, addr, len, wdata, err_at(255 = none)}
    localparam logic [VW-1:0] VECS [0:NV-1] = '{
        {2'd1, 1'b0, 1'b0, 32'h1800_1234, 16'd0,   32'h0,         8'd255},
        {2'd0, 1'b0, 1'b0, 32'h1800_0E00, 16'd0,   32'h0,         8'd255},
        {2'd0, 1'b1, 1'b0, 32'h1800_4ABC, 16'd0,   32'h0000_BEEF, 8'd255},
        {2'd1, 1'b1, 1'b0, 32'h1800_F004, 16'd0,   32'h1234_5678, 8'd255},
        {2'd2, 1'b0, 1'b0, 32'h1801_0100, 16'd336, 32'h0,         8'd255},
        {2'd2, 1'b1, 1'b1, 32'h1801_0104, 16'd256, 32'h0,         8'd255},
        {2'd2, 1'b0, 1'b1, 32'h1801_0000, 16'd6,   32'h0,         8'd255},
        {2'd2, 1'b0, 1'b0, 32'h1801_0020, 16'd40,  32'h0,         8'd255},
        {2'd3, 1'b0, 1'b0, 32'h1801_0000, 16'd0,   32'h0,         8'd255},
        {2'd1, 1'b0, 1'b0, 32'h2000_0010, 16'd0,   32'h0,         8'd2},
        {2'd0, 1'b0, 1'b0, 32'h2000_0010, 16'd0,   32'h0,         8'd255},
        {2'd1, 1'b1, 1'b0, 32'h2000_7FFC, 16'd0,   32'hCAFE_F00D, 8'd0},
        {2'd0, 1'b0, 1'b0, 32'h2000_0002, 16'd0,   32'h0,         8'd255},
        {2'd2, 1'b1, 1'b0, 32'h2000_0000, 16'd0,   32'h0,         8'd255},
        {2'd0, 1'b0, 1'b0, 32'h3000_8000, 16'd0,   32'h0,         8'd255},
        {2'd1, 1'b1, 1'b0, 32'h3000_0010, 16'd0,   32'hDEAD_0001, 8'd255}
    };

    function automatic string vtag(input int i);
        case (i)
            0: return "R2";  1: return "R3";  2: return "R5";  3: return "R6";
            4: return "R7";  5: return "R4";  6: return "R8";  7: return "R7";
            8: return "R8";  9: return "R9";  10: return "R9"; 11: return "R9";
            12: return "R3"; 13: return "R8"; 14: return "R4"; default: return "R6";
        endcase
    endfunction

    function automatic logic [73:0] pk(input logic ext, input logic wr, input logic blk,
                                       input logic inc, input logic [16:0] a,
                                       input logic [8:0] c, input logic [7:0] b,
                                       input logic [31:0] d);
        return {ext, wr, 1'b0, 3'd1, blk, inc, a, c, b, d};
    endfunction

    task automatic check(input string tag, input string what, input logic [73:0] act,
                         input logic [73:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Model of the requirements: expected commands, result and shadow
    task automatic build_exp(input logic [1:0] kind, input logic wr, input logic wide,
                             input logic [31:0] addr, input int len, input int err_at);
        logic miss, flag;
        logic [16:0] off;
        int w, blocks, c, full;
        n_exp = 0;
        w = wide ? 4 : 2;
        if (kind == 2'd3 || (kind == 2'd2 && (len == 0 || (len % w) != 0))) begin
            exp_err = 1'b1;
            exp_rd = '0;
            return;
        end
        miss = !m_ok || (m_base != addr[31:16]);
        if (miss) begin
            expc[n_exp++] = pk(0, 1, 0, 0, 17'h1000A, 9'd0, 8'h00, 32'h0);
            expc[n_exp++] = pk(0, 1, 0, 0, 17'h1000B, 9'd0, addr[23:16], 32'h0);
            expc[n_exp++] = pk(0, 1, 0, 0, 17'h1000C, 9'd0, addr[31:24], 32'h0);
        end
        flag = (kind == 2'd1) || (kind == 2'd2 && wide);
        off = {1'b0, flag, addr[14:0]};
        if (kind != 2'd2) begin
            expc[n_exp++] = pk(1, wr, 0, 1, off, (kind == 2'd1) ? 9'd4 : 9'd2, 8'h00,
                               wr ? req_wdata : 32'h0);
            if (kind == 2'd1 && wr) expc[n_exp++] = pk(1, 0, 0, 1, off, 9'd4, 8'h00, 32'h0);
        end else begin
            blocks = len / 64;
            while (blocks > 0) begin
                c = (blocks > MAXB) ? MAXB : blocks;
                expc[n_exp++] = pk(1, wr, 1, 0, off, 9'(c), 8'h00, 32'h0);
                blocks -= c;
            end
            if ((len % 64) != 0) expc[n_exp++] = pk(1, wr, 0, 0, off, 9'(len % 64), 8'h00, 32'h0);
        end
        full = n_exp;
        if (err_at < full) begin
            n_exp = err_at + 1;
            exp_err = 1'b1;
            exp_rd = '0;
            if (miss) begin
                m_ok = (err_at >= 3);
                m_base = addr[31:16];
            end
        end else begin
            exp_err = 1'b0;
            exp_rd = (kind != 2'd2 && !wr) ? RD_BASE + (miss ? 32'd3 : 32'd0) : 32'h0;
            if (miss) begin
                m_ok = 1'b1;
                m_base = addr[31:16];
            end
        end
    endtask

    // Drive one request and answer every command until done
    task automatic run_req(input logic [1:0] kind, input logic wr, input logic wide,
                           input logic [31:0] addr, input int len, input logic [31:0] wd,
                           input int err_at, input string tag);
        bit seen;
        seen = 0;
        n_got = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_write = wr; req_wide = wide;
        req_addr = addr; req_len = LEN_W'(len); req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int it = 0; it < 400 && !seen; it++) begin
            if (done_valid) begin
                seen = 1;
                got_err = done_err;
                got_rd = done_rdata;
            end else if (cmd_valid) begin
                got[n_got] = {cmd_ext, cmd_write, cmd_raw, cmd_func, cmd_block, cmd_incr,
                              cmd_addr, cmd_count, cmd_byte, cmd_wdata};
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                check("R10", "cmd_valid low while awaiting response", {73'h0, cmd_valid}, 74'h0);
                rsp_valid = 1'b1;
                rsp_err = (n_got == err_at);
                rsp_rdata = RD_BASE + 32'(n_got);
                @(negedge clk);
                rsp_valid = 1'b0;
                rsp_err = 1'b0;
                if (n_got < 31) n_got++;
            end else begin
                @(negedge clk);
            end
        end
        check(tag, "completion seen", {73'h0, seen}, 74'h1);
        @(negedge clk);
        check("R10", "done is a one-cycle pulse", {73'h0, done_valid}, 74'h0);
    endtask

    task automatic compare(input string tag, input int v);
        check(tag, $sformatf("vec %0d command count", v), 74'(n_got), 74'(n_exp));
        for (int i = 0; i < n_exp && i < n_got; i++)
            check(tag, $sformatf("vec %0d command %0d", v, i), got[i], expc[i]);
        check(tag, $sformatf("vec %0d done_err", v), {73'h0, got_err}, {73'h0, exp_err});
        check(tag, $sformatf("vec %0d done_rdata", v), 74'(got_rd), 74'(exp_rd));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        check("R1", "req_ready after reset", {73'h0, req_ready}, 74'h1);
        check("R1", "cmd_valid after reset", {73'h0, cmd_valid}, 74'h0);
        check("R1", "done_valid after reset", {73'h0, done_valid}, 74'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] e;
            e = VECS[v];
            req_wdata = e[39:8];
            build_exp(e[91:90], e[89], e[88], e[87:56], int'(e[55:40]), int'(e[7:0]));
            run_req(e[91:90], e[89], e[88], e[87:56], int'(e[55:40]), e[39:8],
                    int'(e[7:0]), vtag(v));
            compare(vtag(v), v);
        end

        // R10: a response with nothing pending is ignored
        @(negedge clk);
        rsp_valid = 1'b1; rsp_err = 1'b1;
        @(negedge clk);
        rsp_valid = 1'b0; rsp_err = 1'b0;
        check("R10", "stray response gives no done", {73'h0, done_valid}, 74'h0);
        check("R10", "stray response gives no command", {73'h0, cmd_valid}, 74'h0);
        check("R10", "stray response leaves block ready", {73'h0, req_ready}, 74'h1);

        // R1: reset in the middle of a hit sequence invalidates the shadow
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b0; req_wide = 1'b0;
        req_addr = 32'h3000_0004; req_len = '0;
        @(negedge clk);
        req_valid = 1'b0;
        for (int it = 0; it < 10 && !cmd_valid; it++) @(negedge clk);
        check("R3", "hit issues data command first", {57'h0, cmd_addr}, 74'h0_0004);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "req_ready in reset", {73'h0, req_ready}, 74'h1);
        check("R1", "cmd_valid in reset", {73'h0, cmd_valid}, 74'h0);
        rst_n = 1'b1;
        m_ok = 1'b0;
        req_wdata = '0;
        build_exp(2'd0, 1'b0, 1'b0, 32'h3000_0004, 0, 255);
        run_req(2'd0, 1'b0, 1'b0, 32'h3000_0004, 0, 32'h0, 255, "R1");
        compare("R1", 99);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule